// File: doc/BRIEF.md
# Dual-Path Instruction Prefetch Buffer

This block sits between instruction memory and the decode stage. It fetches ahead into small queues, so that decode can keep taking instructions while memory is slow and memory can keep working while decode stalls. In normal running, one queue (the primary queue) collects the fall-through instruction stream and feeds decode. The other queue (the secondary queue) stays empty.

When a conditional branch is reported, the secondary queue starts to collect the branch-target stream. At the same time, the primary queue keeps collecting the fall-through stream. Fetch requests alternate between the two streams each cycle. Fall-through instructions fetched after the report are held back from decode until the branch resolves.

On resolution, the losing queue is emptied. For a taken branch, the two queues swap roles in the same cycle, so the target queue needs no copy. For a not-taken branch, the held fall-through entries are released. An unconditional jump redirects fetch at once and drops the fall-through word still in flight.

Memory returns each word exactly one cycle after its request is accepted. There is therefore never more than one request in flight.

Top module: `twin_prefetch`

## Requirements
- R1: After reset both queues are empty and no branch is pending. `dec_valid` is 0. The first request is for address `RESET_ADDR` with `mem_req_tgt` = 0.
- R2: With no branch pending, only the fall-through stream is requested (`mem_req_tgt` = 0). Accepted request addresses rise by DW/8 (4 bytes). Decode receives the words in address order, each with its own address and the data that memory returned for that address.
- R3: Each queue holds at most DEPTH (4) words, counting the word in flight. With decode stalled, the request output drops to 0 once the primary queue is full, and no word is lost when decode resumes.
- R4: When `br_detect` = 1 with `br_cond` = 1 and no branch is pending, the next accepted request is for `br_target` with `mem_req_tgt` = 1. After that, requests alternate between the fall-through and target streams while both queues have room.
- R5: While a conditional branch is pending, fall-through words that land in the detect cycle or later are not delivered to decode. Decode stalls when such a word reaches the head of the queue.
- R6: A not-taken resolution (`br_resolve` = 1, `br_taken` = 0) discards the target queue and releases the held fall-through words in the next cycle. Fetch then carries on along the fall-through stream only, with no address skipped.
- R7: A taken resolution discards the fall-through queue. In the next cycle decode sees the target words, starting at the branch target and in address order. The next request continues 4 bytes past the last target request and has `mem_req_tgt` = 0.
- R8: An unconditional jump (`br_detect` = 1, `br_cond` = 0) keeps the words already queued and drops the fall-through word that lands in the detect cycle. The next request is for the jump target, with `mem_req_tgt` = 0.
- R9: No request is issued in any cycle in which `br_detect` or `br_resolve` is 1. `dec_valid` is 0 in the cycle in which a resolution is applied.
- R10: A `br_detect` while a branch is pending is ignored, so the target stream stays on the first target. A `br_resolve` with no branch pending is ignored: nothing is flushed and the delivery order is unchanged.
- R11: While `mem_req_valid` = 1 and `mem_req_ready` = 0, with no branch activity, the request address holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req_valid | output | 1 | Fetch request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Fetch address |
| mem_req_tgt | output | 1 | 1 when the request belongs to the branch-target stream |
| mem_rsp_valid | input | 1 | Returned word, one cycle after acceptance |
| mem_rsp_data | input | DW | Returned instruction word |
| br_detect | input | 1 | Branch reported |
| br_cond | input | 1 | 1 for conditional branch, 0 for unconditional jump |
| br_target | input | AW | Branch target address |
| br_resolve | input | 1 | Pending conditional branch resolved |
| br_taken | input | 1 | Resolution outcome |
| dec_valid | output | 1 | Instruction available to decode |
| dec_ready | input | 1 | Decode takes the instruction |
| dec_addr | output | AW | Address of the delivered instruction |
| dec_data | output | DW | Delivered instruction word |

## Verification
The hardest state to reach is a pending conditional branch in which both queues hold words and one request is in flight when the resolution arrives. The fall-through queue must hold its shadow words behind older ones that are still deliverable. To get there, the bench keeps decode always ready, so the queue runs about one word deep and a request goes out every cycle. It then raises the branch report for a single cycle and lets the alternating fetch fill both queues before resolving. Request and delivery logs then show which stream survived, where fetch resumed, and that the in-flight word of the losing stream never reached decode.

// File: rtl/twin_prefetch.sv
module twin_prefetch #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int DEPTH = 4,
  parameter logic [AW-1:0] RESET_ADDR = 'h100
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  output logic          mem_req_tgt,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  input  logic          br_detect,
  input  logic          br_cond,
  input  logic [AW-1:0] br_target,
  input  logic          br_resolve,
  input  logic          br_taken,
  output logic          dec_valid,
  input  logic          dec_ready,
  output logic [AW-1:0] dec_addr,
  output logic [DW-1:0] dec_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW:0] DEPC = (CW+1)'(DEPTH);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  logic [AW-1:0]    q_addr [2][DEPTH];
  logic [DW-1:0]    q_data [2][DEPTH];
  logic [DEPTH-1:0] q_sh   [2];
  logic [PW-1:0]    rd_p   [2];
  logic [PW-1:0]    wr_p   [2];
  logic [CW-1:0]    cnt    [2];
  logic [AW-1:0]    fa     [2];

  logic pri, sec, pend, alt, inf_v, inf_q;
  logic [AW-1:0] inf_a;

  logic ev_det, ev_cond, ev_jmp, ev_res;
  logic rq, want, acc, land, kill, wr_en, wr_sh, pop, head_sh;
  logic [1:0] room, wq, pq, fq;

  assign sec     = ~pri;
  assign ev_det  = br_detect & ~pend;
  assign ev_cond = ev_det & br_cond;
  assign ev_jmp  = ev_det & ~br_cond;
  assign ev_res  = br_resolve & pend;

  always_comb begin
    logic [CW:0] occ;
    for (int q = 0; q < 2; q++) begin
      occ = {1'b0, cnt[q]} + {{CW{1'b0}}, inf_v & (inf_q == q[0])};
      room[q] = occ < DEPC;
    end
  end

  always_comb begin
    if (!pend) begin
      rq = pri;
      want = room[pri];
    end else if (room[pri] && room[sec]) begin
      rq = alt ? sec : pri;
      want = 1'b1;
    end else begin
      rq = room[sec] ? sec : pri;
      want = room[pri] | room[sec];
    end
  end

  assign mem_req_valid = want & ~br_detect & ~br_resolve;
  assign mem_req_addr  = fa[rq];
  assign mem_req_tgt   = rq ^ pri;
  assign acc           = mem_req_valid & mem_req_ready;

  assign land  = inf_v & mem_rsp_valid;
  assign kill  = (ev_res & (inf_q == (br_taken ? pri : sec))) | (ev_jmp & (inf_q == pri));
  assign wr_en = land & ~kill;
  assign wr_sh = (inf_q == pri) & ((pend & ~ev_res) | ev_cond);

  assign head_sh   = q_sh[pri][rd_p[pri]];
  assign dec_valid = (cnt[pri] != '0) & ~(pend & head_sh) & ~ev_res;
  assign dec_addr  = q_addr[pri][rd_p[pri]];
  assign dec_data  = q_data[pri][rd_p[pri]];
  assign pop       = dec_valid & dec_ready;

  always_comb begin
    for (int q = 0; q < 2; q++) begin
      wq[q] = wr_en & (inf_q == q[0]);
      pq[q] = pop & (pri == q[0]);
      fq[q] = ev_res & (br_taken ? (pri == q[0]) : (sec == q[0]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int q = 0; q < 2; q++) begin
        rd_p[q] <= '0;
        wr_p[q] <= '0;
        cnt[q]  <= '0;
        q_sh[q] <= '0;
      end
      fa[0] <= RESET_ADDR;
      fa[1] <= '0;
      pri   <= 1'b0;
      pend  <= 1'b0;
      alt   <= 1'b0;
      inf_v <= 1'b0;
      inf_q <= 1'b0;
      inf_a <= '0;
    end else begin
      for (int q = 0; q < 2; q++) begin
        if (wq[q]) begin
          q_addr[q][wr_p[q]] <= inf_a;
          q_data[q][wr_p[q]] <= mem_rsp_data;
          q_sh[q][wr_p[q]]   <= wr_sh;
        end
        if (ev_res && !br_taken && pri == q[0]) q_sh[q] <= '0;
        if (fq[q]) begin
          rd_p[q] <= '0;
          wr_p[q] <= '0;
          cnt[q]  <= '0;
        end else begin
          rd_p[q] <= rd_p[q] + PW'(pq[q]);
          wr_p[q] <= wr_p[q] + PW'(wq[q]);
          cnt[q]  <= cnt[q] + CW'(wq[q]) - CW'(pq[q]);
        end
        if (acc && rq == q[0])       fa[q] <= fa[q] + STEP;
        if (ev_cond && sec == q[0])  fa[q] <= br_target;
        if (ev_jmp && pri == q[0])   fa[q] <= br_target;
      end
      inf_v <= acc;
      if (acc) begin
        inf_q <= rq;
        inf_a <= fa[rq];
      end
      if (ev_cond) begin
        pend <= 1'b1;
        alt  <= 1'b1;
      end else if (acc && pend) begin
        alt <= (rq == pri);
      end
      if (ev_res) begin
        pend <= 1'b0;
        if (br_taken) pri <= sec;
      end
    end
  end

  p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt[0]} <= DEPC) && ({1'b0, cnt[1]} <= DEPC));

  p_idle_seq_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |-> !(mem_req_valid && mem_req_tgt));

  p_event_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (br_detect || br_resolve) |=> !inf_v);

  p_loser_flushed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (br_resolve && pend) |=> (cnt[~pri] == '0));

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !pend && !br_detect && !br_resolve)
      |=> (!mem_req_valid || mem_req_addr == $past(mem_req_addr)));
endmodule

// File: tb/twin_prefetch_bench.sv
`timescale 1ns/100ps
module twin_prefetch_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic mem_req_valid, mem_req_ready, mem_req_tgt, mem_rsp_valid;
  logic [31:0] mem_req_addr, mem_rsp_data, br_target, dec_addr, dec_data;
  logic br_detect, br_cond, br_resolve, br_taken, dec_valid, dec_ready;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] rq_addr [0:2047];
  bit          rq_tgt  [0:2047];
  logic [31:0] dl_addr [0:2047];
  logic [31:0] dl_data [0:2047];
  int nrq = 0, ndl = 0;

  always #2.5 clk = ~clk;

  twin_prefetch u_twin_prefetch (
    .clk(clk), .rst_n(rst_n),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_tgt(mem_req_tgt),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .br_detect(br_detect), .br_cond(br_cond), .br_target(br_target),
    .br_resolve(br_resolve), .br_taken(br_taken),
    .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_addr(dec_addr), .dec_data(dec_data)
  );

  function automatic logic [31:0] img(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
    end else begin
      mem_rsp_valid <= mem_req_valid & mem_req_ready;
      mem_rsp_data  <= img(mem_req_addr);
      if (mem_req_valid && mem_req_ready && nrq < 2048) begin
        rq_addr[nrq] <= mem_req_addr;
        rq_tgt[nrq]  <= mem_req_tgt;
        nrq <= nrq + 1;
      end
      if (dec_valid && dec_ready && ndl < 2048) begin
        dl_addr[ndl] <= dec_addr;
        dl_data[ndl] <= dec_data;
        ndl <= ndl + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic contig(input int from, input int to, input string req);
    bit ok = 1;
    logic [31:0] a = 0, e = 0;
    for (int k = from; k <= to; k++) begin
      if (ok && dl_data[k] != img(dl_addr[k])) begin
        ok = 0; a = dl_data[k]; e = img(dl_addr[k]);
      end
      if (ok && k < to && dl_addr[k+1] != dl_addr[k] + 4) begin
        ok = 0; a = dl_addr[k+1]; e = dl_addr[k] + 4;
      end
    end
    chk(ok && to > from, req, a, e);
  endtask

  task automatic t_reset;
    rst_n = 0; mem_req_ready = 1; dec_ready = 0;
    br_detect = 0; br_cond = 0; br_target = 0; br_resolve = 0; br_taken = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(dec_valid == 0, "R1 dec_valid", 32'(dec_valid), 0);
    chk(mem_req_valid && mem_req_addr == 32'h100 && !mem_req_tgt, "R1 first req",
        mem_req_addr, 32'h100);
  endtask

  task automatic t_seq;
    dec_ready = 1;
    cyc(20);
    chk(ndl >= 10, "R2 delivered count", ndl, 10);
    chk(dl_addr[0] == 32'h100, "R2 first addr", dl_addr[0], 32'h100);
    contig(0, ndl - 1, "R2 order");
  endtask

  task automatic t_full;
    int nd;
    dec_ready = 0;
    cyc(8);
    nd = ndl;
    chk(mem_req_valid == 0, "R3 full stops requests", 32'(mem_req_valid), 0);
    cyc(3);
    chk(ndl == nd, "R3 no delivery while stalled", ndl, nd);
    dec_ready = 1;
    cyc(12);
    contig(0, ndl - 1, "R3 nothing lost");
  endtask

  task automatic t_stall;
    logic [31:0] a;
    cyc(1);
    mem_req_ready = 0;
    #1;
    a = mem_req_addr;
    cyc(4);
    chk(mem_req_valid && mem_req_addr == a, "R11 addr held", mem_req_addr, a);
    mem_req_ready = 1;
    cyc(10);
    contig(0, ndl - 1, "R11 resume");
  endtask

  task automatic t_not_taken;
    int n0, nr, nd;
    bit ok;
    cyc(1);
    br_detect = 1; br_cond = 1; br_target = 32'h1000;
    #1;
    chk(!mem_req_valid, "R9 no req on detect", 32'(mem_req_valid), 0);
    n0 = nrq;
    cyc(1);
    br_detect = 0;
    cyc(11);
    chk(rq_tgt[n0] && rq_addr[n0] == 32'h1000, "R4 first target req", rq_addr[n0], 32'h1000);
    chk(!rq_tgt[n0+1], "R4 alternate to seq", 32'(rq_tgt[n0+1]), 0);
    chk(rq_tgt[n0+2] && rq_addr[n0+2] == 32'h1004, "R4 alternate to target", rq_addr[n0+2], 32'h1004);
    chk(dec_valid == 0, "R5 shadow held", 32'(dec_valid), 0);
    nd = ndl;
    cyc(3);
    chk(ndl == nd, "R5 no delivery pending", ndl, nd);
    br_resolve = 1; br_taken = 0;
    #1;
    chk(!dec_valid && !mem_req_valid, "R9 quiet on resolve", {dec_valid, mem_req_valid}, 0);
    nr = nrq;
    cyc(1);
    br_resolve = 0;
    #1;
    chk(dec_valid == 1, "R6 release", 32'(dec_valid), 1);
    cyc(12);
    contig(0, ndl - 1, "R6 seq continues");
    ok = 1;
    for (int k = nr; k < nrq; k++) if (rq_tgt[k]) ok = 0;
    chk(ok, "R6 seq only after resolve", 32'(ok), 1);
  endtask

  task automatic t_taken;
    int n0, nr, nd0;
    logic [31:0] lt = 0, first_t = 0;
    bit ok = 1, seen = 0;
    cyc(1);
    br_detect = 1; br_cond = 1; br_target = 32'h2000;
    #1;
    n0 = nrq;
    cyc(1);
    br_detect = 0;
    cyc(1);
    br_detect = 1; br_target = 32'h3000;
    #1;
    chk(!mem_req_valid, "R9 no req on second detect", 32'(mem_req_valid), 0);
    cyc(1);
    br_detect = 0;
    cyc(10);
    for (int k = n0; k < nrq; k++) if (rq_tgt[k]) begin
      if (!seen) first_t = rq_addr[k];
      seen = 1;
      lt = rq_addr[k];
      if (rq_addr[k] >= 32'h3000) ok = 0;
    end
    chk(ok && first_t == 32'h2000, "R10 second detect ignored", first_t, 32'h2000);
    br_resolve = 1; br_taken = 1;
    #1;
    nd0 = ndl; nr = nrq;
    cyc(1);
    br_resolve = 0;
    cyc(15);
    chk(dl_addr[nd0] == 32'h2000, "R7 target first", dl_addr[nd0], 32'h2000);
    contig(nd0, ndl - 1, "R7 target order");
    chk(rq_addr[nr] == lt + 4 && !rq_tgt[nr], "R7 fetch resumes", rq_addr[nr], lt + 4);
  endtask

  task automatic t_jump;
    int nr, nd0, idx;
    logic [31:0] ad;
    bit ok = 1;
    cyc(3);
    ad = rq_addr[nrq-1];
    br_detect = 1; br_cond = 0; br_target = 32'h4000;
    #1;
    nr = nrq; nd0 = ndl;
    cyc(1);
    br_detect = 0;
    cyc(12);
    idx = -1;
    for (int k = nd0; k < ndl; k++) begin
      if (dl_addr[k] == ad) ok = 0;
      if (idx < 0 && dl_addr[k] == 32'h4000) idx = k;
    end
    chk(ok, "R8 in-flight dropped", ad, 0);
    chk(idx > 0 && dl_addr[idx-1] == ad - 4, "R8 queued kept", idx > 0 ? dl_addr[idx-1] : 0, ad - 4);
    chk(rq_addr[nr] == 32'h4000 && !rq_tgt[nr], "R8 fetch at target", rq_addr[nr], 32'h4000);
    contig(idx < 0 ? 0 : idx, ndl - 1, "R8 target order");
  endtask

  task automatic t_spurious;
    int nd0;
    cyc(1);
    br_resolve = 1; br_taken = 1;
    #1;
    nd0 = ndl;
    cyc(1);
    br_resolve = 0;
    cyc(10);
    chk(ndl > nd0 + 5, "R10 delivery continues", ndl, nd0 + 6);
    contig(nd0 - 1, ndl - 1, "R10 lone resolve ignored");
  endtask

  initial begin
    t_reset;
    t_seq;
    t_full;
    t_stall;
    t_not_taken;
    t_taken;
    t_jump;
    t_spurious;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule